// File: doc/BRIEF.md
# Flag-Setting Adder Subtractor

This block is a 32-bit integer arithmetic unit with four operations: add, add with carry, subtract and subtract with carry. Each accepted operation returns a result one clock later. It also computes four condition flags: negative, zero, carry and overflow. The flags sit in a register inside the unit. That register is written only when the operation asks for it.

The carry-in for the two carry-using operations comes from the stored carry flag. Subtraction follows the inverted-borrow convention. A stored carry of 1 means "no borrow", so subtract with carry behaves as a plain subtract. A stored carry of 0 takes one extra unit away. Operations can be issued on consecutive cycles. Each one sees the carry left by the operation issued the cycle before.

Top module: `flag_arith_unit`

## Requirements
- R1: While reset is low and after it is released, `flagN`, `flagZ`, `flagC`, `flagV` and `resVld` are all 0 until the first accepted operation.
- R2: An operation sampled with `inVld`=1 at a rising edge produces `result` and `resVld`=1 after that edge. `resVld` is 0 in cycles that follow an edge with `inVld`=0. The `op` encoding is 00 add, 01 add with carry, 10 subtract, 11 subtract with carry.
- R3: For add (00), `result` = A+B modulo 2^32, and carry is 1 exactly when that result is unsigned-less-than A.
- R4: For add with carry (01), the carry-in is the stored carry. With carry-in 0 it behaves as add. With carry-in 1, `result` = A+B+1 and carry is 1 when the result is unsigned-less-than-or-equal to A.
- R5: For subtract (10), `result` = A-B, and carry is 1 when A is unsigned-greater-than-or-equal to B (no borrow).
- R6: For subtract with carry (11), the carry-in is the stored carry. With carry-in 0, `result` = A-B-1 and carry is A unsigned-greater-than B. With carry-in 1, it behaves as subtract.
- R7: Negative equals bit 31 of the result. Zero is 1 exactly when the result is all zeros.
- R8: Overflow is bit 31 of (NOT(A XOR B)) AND (A XOR result) for add and add with carry. It is bit 31 of (A XOR B) AND (A XOR result) for subtract and subtract with carry.
- R9: The flag register is written only for an operation accepted with `setFlags`=1. Operations with `setFlags`=0 leave the flags unchanged. So does `setFlags`=1 with `inVld`=0.
- R10: An operation issued in the cycle right after a flag-setting operation uses the carry that operation produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inVld | input | 1 | Operation present this cycle |
| op | input | 2 | Operation code (00 add, 01 adc, 10 sub, 11 sbc) |
| setFlags | input | 1 | Write the flag register with this operation's flags |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| result | output | 32 | Registered result |
| resVld | output | 1 | `result` holds a new value |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry flag |
| flagV | output | 1 | Stored overflow flag |

## Verification
`result`, `resVld` and the flags written by an operation all appear after the same single rising edge that samples the operation. An operation issued on the next cycle already sees the new carry. The driver presents every operation at a falling edge and pushes its expected result and flag state into a queue. The monitor compares outputs at the following falling edge, exactly one cycle later, whenever `resVld` is high. The expected flag state follows a carry model kept in the bench. That model is updated only by operations with `setFlags` set, so chained carry use and flag holding are both checked against when each value is due.

// File: rtl/fsau_pkg.sv
`timescale 1ns/1ps
package fsau_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } opKind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadRes;
    logic loadFlags;
    logic doSub;
    logic cin;
  } strobes_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam int CARRY_BEHAV  = 0;
  localparam int CARRY_RIPPLE = 1;

endpackage

// File: rtl/fsau_ctrl.sv
`timescale 1ns/1ps
module fsau_ctrl
  import fsau_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inVld,
  input  logic [1:0] op,
  input  logic     setFlags,
  input  logic     storedC,
  output strobes_t strb,
  output logic     resVld
);

  opKind_e opKind;
  assign opKind = opKind_e'(op);

  always_comb begin
    strb.loadRes   = inVld;
    strb.loadFlags = inVld & setFlags;
    case (opKind)
      OP_ADD: begin strb.doSub = 1'b0; strb.cin = 1'b0;    end
      OP_ADC: begin strb.doSub = 1'b0; strb.cin = storedC; end
      OP_SUB: begin strb.doSub = 1'b1; strb.cin = 1'b1;    end
      default: begin strb.doSub = 1'b1; strb.cin = storedC; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) resVld <= 1'b0;
    else       resVld <= inVld;
  end

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(inVld) |-> resVld); // R2

  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inVld) |-> !resVld); // R2

endmodule

// File: rtl/fsau_dp.sv
`timescale 1ns/1ps
module fsau_dp
  import fsau_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int CARRY_STYLE = CARRY_BEHAV
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] resultQ,
  output flags_t           flagsQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOp;
  logic [WIDTH-1:0] sumBits;
  logic             carryOut;
  flags_t           flagsD;

  // Subtraction adds the inverted operand; the carry-in supplies the +1.
  assign bOp = strb.doSub ? ~opB : opB;

  generate
    if (CARRY_STYLE == CARRY_RIPPLE) begin : gRipple
      logic [WIDTH:0] chain;
      assign chain[0] = strb.cin;
      for (genvar i = 0; i < WIDTH; i++) begin : gBit
        assign sumBits[i]  = opA[i] ^ bOp[i] ^ chain[i];
        assign chain[i+1]  = (opA[i] & bOp[i]) | (chain[i] & (opA[i] ^ bOp[i]));
      end
      assign carryOut = chain[WIDTH];
    end else begin : gBehav
      logic [WIDTH:0] wide;
      assign wide     = {1'b0, opA} + {1'b0, bOp} + {{WIDTH{1'b0}}, strb.cin};
      assign sumBits  = wide[MSB:0];
      assign carryOut = wide[WIDTH];
    end
  endgenerate

  always_comb begin
    flagsD.n = sumBits[MSB];
    flagsD.z = (sumBits == '0);
    flagsD.c = carryOut;
    flagsD.v = ~(opA[MSB] ^ bOp[MSB]) & (opA[MSB] ^ sumBits[MSB]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else begin
      if (strb.loadRes)   resultQ <= sumBits;
      if (strb.loadFlags) flagsQ  <= flagsD;
    end
  end

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadFlags) |->
      (flagsQ.n == resultQ[MSB]) && (flagsQ.z == (resultQ == '0))); // R7

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadFlags && !strb.doSub) |->
      (flagsQ.c == ($past(strb.cin) ? (resultQ <= $past(opA)) : (resultQ < $past(opA))))); // R4

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadFlags && strb.doSub) |->
      (flagsQ.c == ($past(strb.cin) ? ($past(opA) >= $past(opB)) : ($past(opA) > $past(opB))))); // R6

  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.loadFlags) |->
      (flagsQ.v == ($past(strb.doSub)
        ? (($past(opA[MSB]) ^ $past(opB[MSB])) & ($past(opA[MSB]) ^ resultQ[MSB]))
        : (~($past(opA[MSB]) ^ $past(opB[MSB])) & ($past(opA[MSB]) ^ resultQ[MSB]))))); // R8

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadFlags) |-> $stable(flagsQ)); // R9

endmodule

// File: rtl/flag_arith_unit.sv
`timescale 1ns/1ps
module flag_arith_unit
  import fsau_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int CARRY_STYLE = CARRY_BEHAV
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inVld,
  input  logic [1:0]       op,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             resVld,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  strobes_t strb;
  flags_t   flagsQ;

  fsau_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inVld    (inVld),
    .op       (op),
    .setFlags (setFlags),
    .storedC  (flagsQ.c),
    .strb     (strb),
    .resVld   (resVld)
  );

  fsau_dp #(.WIDTH(WIDTH), .CARRY_STYLE(CARRY_STYLE)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .resultQ (result),
    .flagsQ  (flagsQ)
  );

  assign flagN = flagsQ.n;
  assign flagZ = flagsQ.z;
  assign flagC = flagsQ.c;
  assign flagV = flagsQ.v;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !$past(rstN) |-> !resVld && !flagN && !flagZ && !flagC && !flagV); // R1

endmodule

// File: tb/tb_flag_arith_unit.sv
`timescale 1ns/1ps
module tb_flag_arith_unit;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  flg;   // {n,z,c,v}
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inVld = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        setFlags = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        resVld;
  logic        flagN, flagZ, flagC, flagV;

  int checks = 0;
  int errors = 0;
  logic [3:0] model = 4'b0000;   // {n,z,c,v}
  expItem_t   expQ[$];

  always #2.5 clk = ~clk;

  flag_arith_unit dut (
    .clk(clk), .rstN(rstN), .inVld(inVld), .op(op), .setFlags(setFlags),
    .opA(opA), .opB(opB), .result(result), .resVld(resVld),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  function automatic logic [35:0] refOp(input logic [1:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic cIn);
    logic [31:0] r;
    logic c, v;
    case (o)
      2'b00: begin r = a + b; c = (r < a); end
      2'b01: begin
        if (cIn) begin r = a + b + 32'd1; c = (r <= a); end
        else     begin r = a + b;         c = (r < a);  end
      end
      2'b10: begin r = a - b; c = (a >= b); end
      default: begin
        if (cIn) begin r = a - b;         c = (a >= b); end
        else     begin r = a - b - 32'd1; c = (a > b);  end
      end
    endcase
    if (o[1]) v = (a[31] ^ b[31]) & (a[31] ^ r[31]);
    else      v = ~(a[31] ^ b[31]) & (a[31] ^ r[31]);
    return {r, r[31], (r == 32'd0), c, v};
  endfunction

  task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input string tag);
    logic [35:0] rr;
    expItem_t it;
    @(negedge clk);
    inVld = 1'b1; op = o; opA = a; opB = b; setFlags = sf;
    rr = refOp(o, a, b, model[1]);
    if (sf) model = rr[3:0];
    it.res = rr[35:4];
    it.flg = model;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inVld = 1'b0; setFlags = 1'b0;
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Monitor: result due one cycle after issue, sampled at falling edge.
  always @(negedge clk) begin
    if (rstN && resVld) begin
      if (expQ.size() == 0) begin
        check(32'd1, 32'd0, "R2 unexpected resVld");
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(result, it.res, {it.tag, " result"});
        check({28'd0, flagN, flagZ, flagC, flagV}, {28'd0, it.flg}, {it.tag, " flags nzcv"});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({28'd0, resVld, flagN, flagZ, flagC}, 32'd0, "R1 during reset");
    check({31'd0, flagV}, 32'd0, "R1 during reset V");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check({27'd0, resVld, flagN, flagZ, flagC, flagV}, 32'd0, "R1 after reset");
    idle(1);

    issue(2'b00, 32'd5, 32'd7, 1'b1, "R2 R3 add small");
    issue(2'b00, 32'hFFFF_FFFF, 32'd1, 1'b1, "R3 R7 add wrap zero");
    issue(2'b00, 32'h7FFF_FFFF, 32'd1, 1'b1, "R8 R7 add overflow");
    issue(2'b10, 32'd5, 32'd5, 1'b1, "R5 R7 sub equal");
    issue(2'b10, 32'd3, 32'd5, 1'b1, "R5 sub borrow");
    issue(2'b11, 32'd10, 32'd3, 1'b1, "R6 R10 sbc cin0");
    issue(2'b11, 32'd10, 32'd3, 1'b1, "R6 R10 sbc cin1");
    issue(2'b10, 32'h8000_0000, 32'd1, 1'b1, "R8 sub overflow");
    issue(2'b00, 32'hFFFF_FFFF, 32'd0, 1'b1, "R3 carry clear");
    issue(2'b11, 32'd4, 32'd4, 1'b1, "R6 sbc cin0 equal");
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3 carry set");
    issue(2'b01, 32'hFFFF_FFFF, 32'd0, 1'b1, "R4 R10 adc cin1 wrap");
    issue(2'b01, 32'd5, 32'hFFFF_FFFF, 1'b1, "R4 adc cin1 equal A");
    issue(2'b00, 32'd1, 32'd1, 1'b1, "R3 carry clear again");
    issue(2'b01, 32'd9, 32'd6, 1'b1, "R4 adc cin0");
    issue(2'b00, 32'hFFFF_FFFF, 32'd2, 1'b0, "R9 add no setFlags");
    issue(2'b10, 32'd0, 32'd1, 1'b0, "R9 sub no setFlags");
    idle(2);

    // R9: setFlags high without inVld must not touch flags
    @(negedge clk);
    inVld = 1'b0; op = 2'b00; opA = 32'hFFFF_FFFF; opB = 32'hFFFF_FFFF; setFlags = 1'b1;
    @(negedge clk);
    setFlags = 1'b0;
    check({28'd0, flagN, flagZ, flagC, flagV}, {28'd0, model}, "R9 flags held without inVld");
    check({31'd0, resVld}, 32'd0, "R2 no resVld without inVld");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (k % 5 == 0) rb = ra;
      issue(2'($urandom()), ra, rb, 1'($urandom() % 4 != 0), "R10 random chain");
      if (k % 7 == 3) idle(1);
    end
    idle(3);
    check(expQ.size(), 32'd0, "R2 all results delivered");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule